// File: doc/BRIEF.md
# Repeater Expansion Bus Interface

This block joins one multiport repeater device to a shared expansion bus so that several devices behave as a single, larger repeater. When the local repeater core reports activity on any of its ports, the block pulls an active-low request line and waits for an external arbiter to return an active-low grant. While this device holds the bus it drives NRZ data (including the regenerated preamble supplied by the core) on the data line and collision status on the jam line. When the grant is present but another device is the requester, the block samples both lines and hands the received data or collision type to the local core.

A collision is signalled by a high jam line, and during that time the data line is reused to tell what kind of collision it is: low for a multiport collision, high for a single-port one. An active-low expansion-collision input from the arbiter means that more than one device is active; the block then starts its own jam sequence at once, without waiting for the other devices. The grant and expansion-collision inputs are asynchronous and pass through a synchronizer of configurable depth. The tri-state pads are outside the block; it exposes separate input, output and output-enable signals for each bus line.

Top module: `rptr_xbus_if`

## Requirements
- R1: After reset the request line is high, both output enables are low, no jam is in progress and rx_valid is low.
- R2: The request line goes low one clock edge after core_active is seen high.
- R3: When the grant is asserted (SYNC_STAGES edges after grant_n falls) and this device is requesting, both dat_oe and jam_oe are high.
- R4: Both output enables are low whenever the synchronized grant is deasserted, whatever the request state; they drop SYNC_STAGES edges after grant_n rises, and they are never high while the request line is high.
- R5: While owning the bus with no jam in progress, dat_out equals core_data and jam_out is low.
- R6: While owning the bus during a jam, jam_out is high and dat_out is 0 for a multiport collision and 1 for a single-port collision; the type is taken at the last edge where a collision cause was present (core_multiport high or expansion collision gives multiport).
- R7: While the grant is asserted and this device is not requesting, rx_valid rises one edge after that condition starts, and with jam_in low rx_data carries dat_in as sampled on the previous edge.
- R8: While listening with jam_in high, rx_collision is high, rx_multiport is the inverse of dat_in, and rx_data reads 0.
- R9: An asserted xcol_n starts a multiport jam SYNC_STAGES+1 edges later, with no local collision needed.
- R10: A jam stays active for exactly JAM_CYCLES edges after the last edge at which a collision cause was present.
- R11: The request line is released one edge after both core activity has ended and the jam has completed, and not before.
- R12: Whenever this device is not listening, rx_valid, rx_data, rx_collision and rx_multiport are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_active | input | 1 | Local core reports activity on some port |
| core_data | input | 1 | NRZ data bit to send while owning the bus |
| core_collision | input | 1 | Local core reports a collision |
| core_multiport | input | 1 | Local collision involves more than one port |
| req_n | output | 1 | Active-low bus request to the arbiter |
| grant_n | input | 1 | Active-low grant from the arbiter (asynchronous) |
| xcol_n | input | 1 | Active-low expansion collision from the arbiter (asynchronous) |
| dat_in | input | 1 | Data line value from the pad |
| dat_out | output | 1 | Data line value to drive |
| dat_oe | output | 1 | Data line output enable |
| jam_in | input | 1 | Jam line value from the pad |
| jam_out | output | 1 | Jam line value to drive |
| jam_oe | output | 1 | Jam line output enable |
| jam_active | output | 1 | Local jam sequence in progress |
| rx_valid | output | 1 | Received status is valid |
| rx_data | output | 1 | Received NRZ data bit |
| rx_collision | output | 1 | Another device signals a collision |
| rx_multiport | output | 1 | Received collision is multiport |

## Verification
Each result has a fixed latency: the request line follows core activity after one edge, the output enables follow grant_n after SYNC_STAGES edges, received status follows the pads after one edge once listening, and a jam starts one edge after a local cause or SYNC_STAGES+1 edges after xcol_n. The bench drives inputs a moment after a rising edge and samples a moment after the edge at which a result is due, and it also samples one edge early for the request, enable, rx_valid and jam onset, so a result that arrives a cycle early or late is caught. The jam length and the request release are checked on both sides of the final edge.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef struct packed {
      logic valid;
      logic data;
      logic collision;
      logic multiport;
   } rx_stat_t;

   localparam rx_stat_t RX_IDLE = '{valid: 1'b0, data: 1'b0, collision: 1'b0, multiport: 1'b0};

   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/xbus_sync.sv
module xbus_sync #(
   parameter int   STAGES  = 2,
   parameter int   WIDTH   = 1,
   parameter logic RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("xbus_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= {WIDTH{RST_VAL}};
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/xbus_jam.sv
module xbus_jam #(
   parameter int JAM_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trigger,
   input  logic mp_in,
   output logic busy,
   output logic multiport
);
   localparam int CW = xbus_pkg::cnt_width(JAM_CYCLES);
   localparam logic [CW-1:0] LOAD = CW'(JAM_CYCLES);

   generate
      if (JAM_CYCLES < 1) begin : g_bad
         $error("xbus_jam: JAM_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          mp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mp_q  <= 1'b0;
      end else if (trigger) begin
         cnt_q <= LOAD;
         mp_q  <= mp_in;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy      = (cnt_q != '0);
   assign multiport = mp_q;
endmodule

// File: rtl/xbus_rx.sv
module xbus_rx (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                listen,
   input  logic                dat_in,
   input  logic                jam_in,
   output xbus_pkg::rx_stat_t  stat
);
   import xbus_pkg::*;

   rx_stat_t cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= RX_IDLE;
      end else if (listen) begin
         cap_q.valid     <= 1'b1;
         cap_q.data      <= dat_in & ~jam_in;
         cap_q.collision <= jam_in;
         cap_q.multiport <= jam_in & ~dat_in;
      end else begin
         cap_q <= RX_IDLE;
      end
   end

   assign stat = listen ? cap_q : RX_IDLE;
endmodule

// File: rtl/rptr_xbus_if.sv
module rptr_xbus_if #(
   parameter int SYNC_STAGES = 2,
   parameter int JAM_CYCLES  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic core_active,
   input  logic core_data,
   input  logic core_collision,
   input  logic core_multiport,
   output logic req_n,
   input  logic grant_n,
   input  logic xcol_n,
   input  logic dat_in,
   output logic dat_out,
   output logic dat_oe,
   input  logic jam_in,
   output logic jam_out,
   output logic jam_oe,
   output logic jam_active,
   output logic rx_valid,
   output logic rx_data,
   output logic rx_collision,
   output logic rx_multiport
);
   import xbus_pkg::*;

   logic [1:0] async_in;
   logic [1:0] sync_out;
   logic       grant_s;
   logic       xcol_s;
   logic       req_q;
   logic       owner;
   logic       listen;
   logic       trigger;
   logic       jam_busy;
   logic       jam_mp;
   rx_stat_t   rx_stat;

   assign async_in = {~xcol_n, ~grant_n};

   xbus_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (async_in),
      .q     (sync_out)
   );

   assign grant_s = sync_out[0];
   assign xcol_s  = sync_out[1];

   assign trigger = xcol_s | core_collision;

   xbus_jam #(.JAM_CYCLES(JAM_CYCLES)) u_jam (
      .clk       (clk),
      .rst_n     (rst_n),
      .trigger   (trigger),
      .mp_in     (xcol_s | core_multiport),
      .busy      (jam_busy),
      .multiport (jam_mp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= core_active | jam_busy | trigger;
   end

   assign owner  = grant_s & req_q;
   assign listen = grant_s & ~req_q;

   xbus_rx u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .listen (listen),
      .dat_in (dat_in),
      .jam_in (jam_in),
      .stat   (rx_stat)
   );

   assign req_n        = ~req_q;
   assign dat_oe       = owner;
   assign jam_oe       = owner;
   assign jam_out      = jam_busy;
   assign dat_out      = jam_busy ? ~jam_mp : core_data;
   assign jam_active   = jam_busy;
   assign rx_valid     = rx_stat.valid;
   assign rx_data      = rx_stat.data;
   assign rx_collision = rx_stat.collision;
   assign rx_multiport = rx_stat.multiport;
endmodule

// File: rtl/rptr_xbus_if_chk.sv
module rptr_xbus_if_chk (
   input logic clk,
   input logic rst_n,
   input logic core_active,
   input logic core_collision,
   input logic req_n,
   input logic dat_oe,
   input logic jam_oe,
   input logic jam_active,
   input logic rx_valid,
   input logic rx_collision
);
   assert_req_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      core_active |=> !req_n);

   assert_no_drive_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_n |-> (!dat_oe && !jam_oe));

   assert_jam_retrigger_R10: assert property (@(posedge clk) disable iff (!rst_n)
      core_collision |=> jam_active);

   assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      jam_active |=> !req_n);

   assert_rx_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_oe || jam_oe) |-> (!rx_valid && !rx_collision));
endmodule

bind rptr_xbus_if rptr_xbus_if_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .core_active    (core_active),
   .core_collision (core_collision),
   .req_n          (req_n),
   .dat_oe         (dat_oe),
   .jam_oe         (jam_oe),
   .jam_active     (jam_active),
   .rx_valid       (rx_valid),
   .rx_collision   (rx_collision)
);

// File: tb/rptr_xbus_if_bench.sv
module rptr_xbus_if_bench;
   localparam int SYNC = 2;
   localparam int JAM  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic core_active = 1'b0, core_data = 1'b0, core_collision = 1'b0, core_multiport = 1'b0;
   logic grant_n = 1'b1, xcol_n = 1'b1, dat_in = 1'b0, jam_in = 1'b0;
   logic req_n, dat_out, dat_oe, jam_out, jam_oe, jam_active;
   logic rx_valid, rx_data, rx_collision, rx_multiport;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   rptr_xbus_if #(.SYNC_STAGES(SYNC), .JAM_CYCLES(JAM)) u_rptr_xbus_if (
      .clk(clk), .rst_n(rst_n),
      .core_active(core_active), .core_data(core_data),
      .core_collision(core_collision), .core_multiport(core_multiport),
      .req_n(req_n), .grant_n(grant_n), .xcol_n(xcol_n),
      .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe),
      .jam_in(jam_in), .jam_out(jam_out), .jam_oe(jam_oe),
      .jam_active(jam_active),
      .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_collision(rx_collision), .rx_multiport(rx_multiport)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic t_reset;
      check("R1", "req_n", req_n, 1'b1);
      check("R1", "dat_oe", dat_oe, 1'b0);
      check("R1", "jam_oe", jam_oe, 1'b0);
      check("R1", "jam_active", jam_active, 1'b0);
      check("R1", "rx_valid", rx_valid, 1'b0);
   endtask

   task automatic t_request_and_own;
      core_active = 1'b1;
      core_data = 1'b1;
      tick(1);
      check("R2", "req_n after one edge", req_n, 1'b0);
      check("R4", "dat_oe without grant", dat_oe, 1'b0);
      grant_n = 1'b0;
      tick(SYNC - 1);
      check("R3", "dat_oe one edge early", dat_oe, 1'b0);
      tick(1);
      check("R3", "dat_oe when owner", dat_oe, 1'b1);
      check("R3", "jam_oe when owner", jam_oe, 1'b1);
      check("R5", "dat_out follows core 1", dat_out, 1'b1);
      check("R5", "jam_out idle", jam_out, 1'b0);
      check("R12", "rx_valid while owner", rx_valid, 1'b0);
      core_data = 1'b0;
      #1;
      check("R5", "dat_out follows core 0", dat_out, 1'b0);
   endtask

   task automatic t_grant_drop;
      grant_n = 1'b1;
      tick(SYNC - 1);
      check("R4", "dat_oe one edge before drop", dat_oe, 1'b1);
      tick(1);
      check("R4", "dat_oe after grant drop", dat_oe, 1'b0);
      check("R4", "jam_oe after grant drop", jam_oe, 1'b0);
      check("R2", "req_n still low", req_n, 1'b0);
      grant_n = 1'b0;
      tick(SYNC);
   endtask

   task automatic t_local_jam;
      core_collision = 1'b1;
      core_multiport = 1'b0;
      tick(1);
      check("R6", "jam_active", jam_active, 1'b1);
      check("R6", "jam_out", jam_out, 1'b1);
      check("R6", "dat_out single-port", dat_out, 1'b1);
      core_multiport = 1'b1;
      tick(1);
      check("R6", "dat_out multiport", dat_out, 1'b0);
      core_collision = 1'b0;
      core_multiport = 1'b0;
      core_active = 1'b0;
      tick(JAM - 1);
      check("R10", "jam still active at last cycle", jam_active, 1'b1);
      check("R11", "req_n held during jam", req_n, 1'b0);
      tick(1);
      check("R10", "jam ended", jam_active, 1'b0);
      check("R11", "req_n held until jam done", req_n, 1'b0);
      tick(1);
      check("R11", "req_n released", req_n, 1'b1);
      check("R4", "dat_oe off when not requesting", dat_oe, 1'b0);
   endtask

   task automatic t_listen;
      grant_n = 1'b1;
      tick(SYNC + 1);
      dat_in = 1'b1;
      jam_in = 1'b0;
      tick(1);
      check("R12", "rx_valid without grant", rx_valid, 1'b0);
      check("R12", "rx_data without grant", rx_data, 1'b0);
      grant_n = 1'b0;
      tick(SYNC);
      check("R7", "rx_valid one edge early", rx_valid, 1'b0);
      tick(1);
      check("R7", "rx_valid", rx_valid, 1'b1);
      check("R7", "rx_data 1", rx_data, 1'b1);
      check("R7", "rx_collision idle", rx_collision, 1'b0);
      dat_in = 1'b0;
      tick(1);
      check("R7", "rx_data 0", rx_data, 1'b0);
      jam_in = 1'b1;
      tick(1);
      check("R8", "rx_collision", rx_collision, 1'b1);
      check("R8", "rx_multiport on dat 0", rx_multiport, 1'b1);
      check("R8", "rx_data masked", rx_data, 1'b0);
      dat_in = 1'b1;
      tick(1);
      check("R8", "rx_multiport on dat 1", rx_multiport, 1'b0);
      check("R8", "rx_collision single", rx_collision, 1'b1);
      jam_in = 1'b0;
      dat_in = 1'b0;
   endtask

   task automatic t_expansion_collision;
      core_active = 1'b1;
      tick(1);
      check("R12", "rx cleared once requesting", rx_valid, 1'b0);
      xcol_n = 1'b0;
      tick(SYNC);
      check("R9", "no jam yet", jam_active, 1'b0);
      tick(1);
      check("R9", "jam started by xcol", jam_active, 1'b1);
      check("R9", "dat_out multiport", dat_out, 1'b0);
      check("R9", "jam_out driven", jam_out, 1'b1);
      xcol_n = 1'b1;
      core_active = 1'b0;
      tick(SYNC + JAM + 2);
      check("R10", "jam over after xcol", jam_active, 1'b0);
      check("R11", "req released after xcol jam", req_n, 1'b1);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_request_and_own();
      t_grant_drop();
      t_local_jam();
      t_listen();
      t_expansion_collision();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule